// File: doc/BRIEF.md
# Bipolar Return-to-Zero Word Receiver with Label Acceptance Filter

This block listens to one three-level return-to-zero serial line, presented as two digital legs: a pulse on the high leg carries a one, a pulse on the low leg carries a zero, and both legs low is the null level. Each bit is recovered from its own pulse, so no separate clock travels with the data. The block counts 32 bits into a word and restores every bit to its numbered position: the first eight bits arrive with the label reversed, and the rest arrive in ascending order. A long null stretch closes the word.

A closed 32-bit word is checked for odd parity. It is then looked up in a 256-entry acceptance table, indexed by its 8-bit label, which a CPU-side write port loads. Each entry has an enable bit and a 4-bit mask of allowed source/destination identifier values. The identifier is word bits 9..8. Accepted words leave through a valid/ready stream port.

The output register holds one word. While `out_valid` is high and `out_ready` is low, the word and its flag are frozen. The serial line cannot be paused, so a word that completes while the register is still occupied is dropped. The line and framing faults are reported as single-cycle pulses on plain status pins.

Top module: `bprz_label_rx`

## Requirements
- R1: After reset, `out_valid`, `line_err` and `frame_err` are 0 and every table entry is disabled, so a well-formed word received before any table write is not delivered.
- R2: A high-leg pulse (`leg_hi`=1, `leg_lo`=0) is a one and a low-leg pulse (`leg_hi`=0, `leg_lo`=1) is a zero. The k-th received bit (k counted from 0) is placed at `out_word[7-k]` for k<8 and at `out_word[k]` for 8<=k<32, so the label occupies `out_word[7:0]` with bit number 1 at index 0.
- R3: A null run of `GAP_BITS` bit periods ends the current word. A transmitter leaving 4 null bit times between words has each word received separately.
- R4: A write with `tbl_we`=1 stores {`tbl_sdi_mask`, `tbl_en`} at entry `tbl_addr`. A word is delivered only if the entry at `out_word[7:0]` has the enable bit set and bit `out_word[9:8]` of that entry's mask set.
- R5: `out_par_err` is 1 exactly when the 32-bit word has an even number of ones. Such a word is delivered only while `keep_bad_par`=1, and is otherwise dropped.
- R6: A cell with both legs high raises `line_err` for one cycle. The word in progress is discarded without a framing error, and `line_err` and `frame_err` never pulse in the same cycle.
- R7: A word that ends with fewer or more than 32 bits raises `frame_err` for one cycle and is discarded.
- R8: `rate_slow`=1 selects a bit period of `SLOW_DIV` clocks and 0 selects `FAST_DIV` clocks. At the fast setting, pulses sent with the slow bit period are split apart by their own nulls, which gives framing errors and no word.
- R9: While `out_valid`=1 and `out_ready`=0, `out_word` and `out_par_err` hold steady. A word completing in that time is discarded.
- R10: A word transfers on a clock edge with `out_valid`=1 and `out_ready`=1. `out_valid` then falls unless a new word loads at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| leg_hi | input | 1 | High leg of the line, asynchronous |
| leg_lo | input | 1 | Low leg of the line, asynchronous |
| rate_slow | input | 1 | 1 selects the slow bit period, 0 the fast one |
| keep_bad_par | input | 1 | 1 lets parity-error words through, with the flag set |
| tbl_we | input | 1 | Acceptance table write strobe |
| tbl_addr | input | 8 | Table entry (label value) to write |
| tbl_en | input | 1 | Enable bit for the written entry |
| tbl_sdi_mask | input | 4 | Accepted identifier values for the written entry |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Received word, bit number n at index n-1 |
| out_par_err | output | 1 | Word has even parity |
| line_err | output | 1 | One-cycle pulse: both legs high |
| frame_err | output | 1 | One-cycle pulse: word length not 32 |

## Verification
Both legs pass through two synchronizer flops. The word boundary is then found `GAP_BITS` bit periods into the null after the last pulse. After that, `frame_err` or the assembled word appears one clock later, and `out_valid` one clock after that. Every result is therefore due within `GAP_BITS` bit periods plus four clocks of the last pulse ending. The bench leaves 4 bit periods of null after every word plus four clocks of margin before it compares the delivered-word and error-pulse counters with the expected values. The back-pressure case samples `out_word` while `out_ready` is low, which is well after both words have closed.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;
  localparam int WORD_BITS = 32;
  localparam int LBL_BITS  = 8;
  localparam int SDI_BITS  = 2;
  localparam int MASK_BITS = 1 << SDI_BITS;
  localparam int TBL_DEPTH = 1 << LBL_BITS;
  localparam int CNT_BITS  = $clog2(WORD_BITS + 2);

  typedef struct packed {
    logic [MASK_BITS-1:0] sdi_mask;
    logic                 en;
  } acc_entry_t;

  // {hi, lo} leg pair after synchronization
  typedef enum logic [1:0] {
    LN_NULL = 2'b00,
    LN_ZERO = 2'b01,
    LN_ONE  = 2'b10,
    LN_BAD  = 2'b11
  } line_t;
endpackage

// File: rtl/rzrx_line_decoder.sv
module rzrx_line_decoder
  import rzrx_pkg::*;
#(
  parameter int FAST_DIV    = 2000,
  parameter int SLOW_DIV    = 16000,
  parameter int GAP_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic leg_hi,
  input  logic leg_lo,
  input  logic rate_slow,
  output logic bit_vld,
  output logic bit_val,
  output logic line_bad,
  output logic gap_end
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CNT_W   = $clog2(GAP_BITS * MAX_DIV + 1);

  logic [SYNC_STAGES-1:0] hi_sync, lo_sync;
  line_t                  cur, prev;
  logic [CNT_W-1:0]       idle_cnt, gap_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sync <= '0;
      lo_sync <= '0;
    end else begin
      hi_sync <= {hi_sync[SYNC_STAGES-2:0], leg_hi};
      lo_sync <= {lo_sync[SYNC_STAGES-2:0], leg_lo};
    end
  end

  assign cur     = line_t'({hi_sync[SYNC_STAGES-1], lo_sync[SYNC_STAGES-1]});
  assign gap_lim = rate_slow ? CNT_W'(GAP_BITS * SLOW_DIV) : CNT_W'(GAP_BITS * FAST_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= LN_NULL;
      idle_cnt <= '0;
    end else begin
      prev <= cur;
      if (cur != LN_NULL)         idle_cnt <= '0;
      else if (idle_cnt < gap_lim) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // a bit is the onset of a single-leg pulse out of null
  assign bit_vld  = (prev == LN_NULL) && ((cur == LN_ONE) || (cur == LN_ZERO));
  assign bit_val  = (cur == LN_ONE);
  assign line_bad = (cur == LN_BAD) && (prev != LN_BAD);
  assign gap_end  = (cur == LN_NULL) && (idle_cnt == gap_lim - 1'b1);

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_vld, line_bad, gap_end})); // R6
endmodule

// File: rtl/rzrx_word_builder.sv
module rzrx_word_builder
  import rzrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  input  logic                 line_bad,
  input  logic                 gap_end,
  output logic                 word_vld,
  output logic [WORD_BITS-1:0] word,
  output logic                 frame_err,
  output logic                 line_err
);
  logic [CNT_BITS-1:0]  cnt;
  logic [WORD_BITS-1:0] asm_q;
  logic                 bad;
  logic [4:0]           wr_idx;

  // label arrives high bit first, the rest low bit first
  always_comb begin
    if (cnt < CNT_BITS'(8)) wr_idx = 5'(3'd7 - cnt[2:0]);
    else                    wr_idx = cnt[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      asm_q     <= '0;
      bad       <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
      frame_err <= 1'b0;
      line_err  <= 1'b0;
    end else begin
      word_vld  <= 1'b0;
      frame_err <= 1'b0;
      line_err  <= line_bad;
      if (gap_end && ((cnt != '0) || bad)) begin
        if (!bad) begin
          if (cnt == CNT_BITS'(WORD_BITS)) begin
            word_vld <= 1'b1;
            word     <= asm_q;
          end else begin
            frame_err <= 1'b1;
          end
        end
        cnt   <= '0;
        bad   <= 1'b0;
        asm_q <= '0;
      end else begin
        if (line_bad) bad <= 1'b1;
        if (bit_vld) begin
          if (cnt < CNT_BITS'(WORD_BITS))     asm_q[wr_idx] <= bit_val;
          if (cnt < CNT_BITS'(WORD_BITS + 1)) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_FRAME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && word_vld)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_BITS'(WORD_BITS + 1)); // R7
endmodule

// File: rtl/rzrx_accept_table.sv
module rzrx_accept_table
  import rzrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [LBL_BITS-1:0]  waddr,
  input  acc_entry_t           wdata,
  input  logic                 word_vld,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 keep_bad,
  output logic                 accept,
  output logic                 par_err
);
  acc_entry_t          tbl [TBL_DEPTH];
  acc_entry_t          ent;
  logic [SDI_BITS-1:0] sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  assign ent     = tbl[word[LBL_BITS-1:0]];
  assign sdi     = word[LBL_BITS +: SDI_BITS];
  assign par_err = ~^word;
  assign accept  = word_vld && ent.en && ent.sdi_mask[sdi] && (!par_err || keep_bad);
endmodule

// File: rtl/bprz_label_rx.sv
module bprz_label_rx
  import rzrx_pkg::*;
#(
  parameter int FAST_DIV = 2000,
  parameter int SLOW_DIV = 16000,
  parameter int GAP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 leg_hi,
  input  logic                 leg_lo,
  input  logic                 rate_slow,
  input  logic                 keep_bad_par,
  input  logic                 tbl_we,
  input  logic [LBL_BITS-1:0]  tbl_addr,
  input  logic                 tbl_en,
  input  logic [MASK_BITS-1:0] tbl_sdi_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_BITS-1:0] out_word,
  output logic                 out_par_err,
  output logic                 line_err,
  output logic                 frame_err
);
  logic                 bit_vld, bit_val, line_bad, gap_end;
  logic                 word_vld, accept, par_err, load;
  logic [WORD_BITS-1:0] word;
  acc_entry_t           wentry;

  assign wentry = '{sdi_mask: tbl_sdi_mask, en: tbl_en};

  rzrx_line_decoder #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_BITS(GAP_BITS), .SYNC_STAGES(2)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .leg_hi(leg_hi), .leg_lo(leg_lo), .rate_slow(rate_slow),
    .bit_vld(bit_vld), .bit_val(bit_val), .line_bad(line_bad), .gap_end(gap_end)
  );

  rzrx_word_builder bld_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .line_bad(line_bad), .gap_end(gap_end), .word_vld(word_vld), .word(word),
    .frame_err(frame_err), .line_err(line_err)
  );

  rzrx_accept_table tbl_i (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(wentry),
    .word_vld(word_vld), .word(word), .keep_bad(keep_bad_par),
    .accept(accept), .par_err(par_err)
  );

  // single holding register; the line cannot stall, so a busy slot drops
  assign load = accept && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_par_err <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_word    <= word;
      out_par_err <= par_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_par_err))); // R9
  AST_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par_err == ~^out_word)); // R5
  AST_PAR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (!out_par_err || $past(keep_bad_par))); // R5
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_err && frame_err)); // R6
  AST_DROP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !word_vld) |=> !out_valid); // R10
endmodule

// File: tb/bprz_label_rx_tb_top.sv
module bprz_label_rx_tb_top;
  localparam int FD = 8;
  localparam int SD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        leg_hi = 1'b0, leg_lo = 1'b0;
  logic        rate_slow = 1'b0, keep_bad_par = 1'b0;
  logic        tbl_we = 1'b0, tbl_en = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [3:0]  tbl_sdi_mask = '0;
  logic        out_valid, out_ready = 1'b1, out_par_err, line_err, frame_err;
  logic [31:0] out_word;

  always #2.5 clk = ~clk;

  bprz_label_rx #(.FAST_DIV(FD), .SLOW_DIV(SD), .GAP_BITS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .leg_hi(leg_hi), .leg_lo(leg_lo), .rate_slow(rate_slow),
    .keep_bad_par(keep_bad_par), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_en(tbl_en),
    .tbl_sdi_mask(tbl_sdi_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_par_err(out_par_err), .line_err(line_err), .frame_err(frame_err)
  );

  int          n_checks = 0, n_fail = 0;
  int          nrx = 0, nline = 0, nframe = 0;
  logic [31:0] last_word = '0;
  logic        last_perr = 1'b0;
  logic        done = 1'b0;
  logic        sh_en [256];
  logic [3:0]  sh_mask [256];

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        nrx++;
        last_word = out_word;
        last_perr = out_par_err;
      end
      if (line_err)  nline++;
      if (frame_err) nframe++;
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] odd_fix(input logic [31:0] w);
    logic [31:0] r = w;
    r[31] = 1'b0;
    if (^r == 1'b0) r[31] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_push(input logic [31:0] w, input logic keep);
    return sh_en[w[7:0]] && sh_mask[w[7:0]][w[9:8]] && ((^w) || keep);
  endfunction

  task automatic wr_tbl(input logic [7:0] a, input logic en, input logic [3:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_en = en; tbl_sdi_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
    sh_en[a] = en; sh_mask[a] = m;
  endtask

  // nbits cells, cell bad_at driven with both legs high; then 4 null bit periods
  task automatic send(input logic [31:0] w, input int nbits, input int div, input int bad_at);
    for (int k = 0; k < nbits; k++) begin
      logic b;
      if (k < 8)       b = w[7-k];
      else if (k < 32) b = w[k];
      else             b = 1'b1;
      for (int c = 0; c < div; c++) begin
        @(negedge clk);
        if (c < div / 2) begin
          leg_hi = (k == bad_at) ? 1'b1 : b;
          leg_lo = (k == bad_at) ? 1'b1 : ~b;
        end else begin
          leg_hi = 1'b0; leg_lo = 1'b0;
        end
      end
    end
    repeat (4 * div + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int          p, pl, pf;
    logic [31:0] w, a_w, b_w;
    logic [7:0]  labs [4];
    logic        kb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin sh_en[i] = 1'b0; sh_mask[i] = 4'h0; end

    repeat (5) @(negedge clk);
    check("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "err pulses after reset", {line_err, frame_err}, 0);

    w = odd_fix(32'h1234_5601);
    p = nrx; send(w, 32, FD, -1);
    check("R1", "empty table delivers nothing", nrx, p);

    // R2 bit order: label 0x01 must not come out as 0x80
    wr_tbl(8'h01, 1'b1, 4'hF);
    p = nrx; send(w, 32, FD, -1);
    check("R2", "word delivered", nrx, p + 1);
    check("R2", "bit placement", last_word, w);
    check("R5", "odd word flag clear", last_perr, 0);

    // R4 identifier mask
    wr_tbl(8'h3C, 1'b1, 4'b0100);
    w = odd_fix(32'hA5A5_A23C); // sdi = 2
    p = nrx; send(w, 32, FD, -1);
    check("R4", "sdi 2 accepted", nrx, p + 1);
    check("R4", "sdi 2 word", last_word, w);
    w = odd_fix(32'hA5A5_A13C); // sdi = 1
    p = nrx; send(w, 32, FD, -1);
    check("R4", "sdi 1 rejected", nrx, p);
    wr_tbl(8'h3C, 1'b0, 4'hF);
    w = odd_fix(32'hA5A5_A23C);
    p = nrx; send(w, 32, FD, -1);
    check("R4", "disabled entry rejected", nrx, p);

    // R5 parity handling
    w = odd_fix(32'h0F0F_0001) ^ 32'h8000_0000;
    p = nrx; send(w, 32, FD, -1);
    check("R5", "even word dropped", nrx, p);
    keep_bad_par = 1'b1;
    p = nrx; send(w, 32, FD, -1);
    check("R5", "even word kept", nrx, p + 1);
    check("R5", "even word flag", last_perr, 1);
    keep_bad_par = 1'b0;

    // R6 line fault
    w = odd_fix(32'h2222_2201);
    p = nrx; pl = nline; pf = nframe;
    send(w, 32, FD, 12);
    check("R6", "line_err pulse", nline, pl + 1);
    check("R6", "word discarded", nrx, p);
    check("R6", "no framing error", nframe, pf);

    // R7 short and long words
    pf = nframe; p = nrx; send(w, 20, FD, -1);
    check("R7", "short word frame_err", nframe, pf + 1);
    pf = nframe; send(w, 33, FD, -1);
    check("R7", "long word frame_err", nframe, pf + 1);
    check("R7", "no word delivered", nrx, p);

    // R8 rate selection
    rate_slow = 1'b1;
    repeat (4) @(negedge clk);
    w = odd_fix(32'h7654_3301);
    p = nrx; send(w, 32, SD, -1);
    check("R8", "slow word delivered", nrx, p + 1);
    check("R8", "slow word value", last_word, w);
    rate_slow = 1'b0;
    repeat (4) @(negedge clk);
    p = nrx; pf = nframe; send(w, 32, SD, -1);
    check("R8", "slow pulses at fast rate give no word", nrx, p);
    check("R8", "slow pulses at fast rate give frame errors", (nframe > pf) ? 1 : 0, 1);

    // R9 back-pressure and R10 handshake
    a_w = odd_fix(32'h1111_0001);
    b_w = odd_fix(32'h9999_0001);
    @(posedge clk); #1 out_ready = 1'b0;
    p = nrx;
    send(a_w, 32, FD, -1);
    send(b_w, 32, FD, -1);
    check("R9", "held valid", out_valid, 1);
    check("R9", "held word is first", out_word, a_w);
    check("R9", "nothing transferred", nrx, p);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "one transfer", nrx, p + 1);
    check("R10", "transferred word", last_word, a_w);
    check("R10", "valid dropped after transfer", out_valid, 0);

    // R3 and R10: random words separated by 4 null bit periods
    for (int i = 0; i < 4; i++) begin
      labs[i] = 8'($urandom);
      wr_tbl(labs[i], ($urandom % 5) != 0, 4'($urandom));
    end
    for (int i = 0; i < 40; i++) begin
      w = $urandom;
      w[7:0] = labs[$urandom % 4];
      if (($urandom % 4) != 0) w = odd_fix(w);
      else w = odd_fix(w) ^ 32'h8000_0000;
      kb = 1'($urandom);
      keep_bad_par = kb;
      p = nrx;
      send(w, 32, FD, -1);
      if (exp_push(w, kb)) begin
        check("R3", "random word delivered", nrx, p + 1);
        check("R10", "random word value", last_word, w);
        check("R5", "random parity flag", last_perr, ~^w);
      end else begin
        check("R4", "random word filtered", nrx, p);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule